// File: doc/BRIEF.md
# Interrupt Redirection Table Message Generator

This block routes 24 interrupt input lines into a single message stream. Every input owns a 64-bit redirection entry that software programs through an index register and a 32-bit data window. The entry fixes the vector, whether the input is edge or level sensitive, which level counts as active, whether the input is masked, and an 8-bit mask of destination processors. When an unmasked input becomes active, the block emits a message carrying the vector and the destination mask on a valid/ready port. The receiving processor takes the vector from the message and never reads it back from the router.

The input number implies no priority: inputs that request in the same cycle are taken in round-robin order and the losers stay pending. A level-sensitive input that has been sent is blocked by a remote-pending flag until an end-of-interrupt with the same vector arrives. If the input is still active at that point, it is sent again.

Top module: `irq_redirect_router`

## Requirements
- R1: After reset no message is valid, and the low half of every entry reads 0x0001_0000: masked, edge mode, active high, vector 0.
- R2: The index register selects the low half of entry n at 0x10+2n and the high half at 0x11+2n. Written words read back, except bit 14 of the low half, which software cannot write. An index outside 0x10..0x3F reads 0 and writes nothing.
- R3: A masked input never produces a message.
- R4: In edge mode (bit 15 = 0), each inactive-to-active transition produces exactly one message. Holding the input active sends nothing more. The message vector is bits 7:0 of the entry and the message destination is bits 63:56.
- R5: Bit 13 = 1 makes an input active low, so a falling edge on the pin triggers it.
- R6: In level mode (bit 15 = 1), a message sets the remote-pending flag, readable at bit 14. While the flag is set, no further message goes out for that input. An end-of-interrupt whose vector differs has no effect. A matching one clears the flag, and an input that is still active is sent again.
- R7: A matching end-of-interrupt that arrives while the level input is inactive clears the flag without sending a message.
- R8: Inputs that request at the same time are all delivered, once each. The order is round robin, starting after the input that was granted last.
- R9: An edge that arrives while the input is masked is discarded; clearing the mask later does not send it.
- R10: A level input that is active while masked is sent as soon as the mask is cleared.
- R11: While the message is valid and not accepted, the message and its fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_line_i | input | 24 | Interrupt input pins |
| cfg_sel_we_i | input | 1 | Write strobe for the index register |
| cfg_sel_i | input | 8 | New index value |
| cfg_win_we_i | input | 1 | Write strobe for the data window |
| cfg_win_wdata_i | input | 32 | Data written through the window |
| cfg_win_rdata_o | output | 32 | Word selected by the index |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_vector_i | input | 8 | Vector of the end-of-interrupt |
| msg_valid_o | output | 1 | Message valid |
| msg_ready_i | input | 1 | Message accepted |
| msg_vector_o | output | 8 | Message vector |
| msg_dest_o | output | 8 | Message destination processor mask |

## Verification
A stuck or lost edge-pending bit shows at the port within two cycles of the edge, as a message that is missing, repeated or late. A wrong remote-pending flag shows at once at bit 14 of the window, and within a cycle of the next end-of-interrupt as a resend that is missing or extra. A wrong round-robin pointer shows only when two or more inputs request together, as a delivery order that breaks the cyclic sequence. The bench therefore compares the full order of two consecutive contended bursts.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;
  localparam int ENTRY_W  = 64;
  localparam int VEC_W    = 8;
  localparam int DEST_W   = 8;
  localparam int POL_BIT  = 13;
  localparam int RIRR_BIT = 14;
  localparam int TRIG_BIT = 15;
  localparam int MASK_BIT = 16;
  localparam int DEST_LSB = 56;
  localparam logic [7:0] WIN_BASE = 8'h10;
  localparam logic [ENTRY_W-1:0] RST_ENTRY = ENTRY_W'(1) << MASK_BIT;

  typedef struct packed {
    logic [VEC_W-1:0]  vector;
    logic [DEST_W-1:0] dest;
    logic              active_low;
    logic              level;
    logic              masked;
  } line_cfg_t;
endpackage

// File: rtl/irq_rt_table.sv
module irq_rt_table
  import irq_rt_pkg::*;
#(
  parameter int N  = 24,
  localparam int IW = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_we_i,
  input  logic [7:0]       sel_i,
  input  logic             win_we_i,
  input  logic [31:0]      win_wdata_i,
  output logic [31:0]      win_rdata_o,
  input  logic [N-1:0]     rirr_i,
  output line_cfg_t        cfg_o [N]
);
  logic [7:0]         sel_q;
  logic [7:0]         off;
  logic               hit;
  logic               hi;
  logic [IW-1:0]      ent;
  logic [ENTRY_W-1:0] entry_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q <= '0;
    else if (sel_we_i) sel_q <= sel_i;
  end

  assign off = sel_q - WIN_BASE;
  assign hit = (sel_q >= WIN_BASE) && (32'(off[7:1]) < N);
  assign hi  = off[0];
  assign ent = off[IW:1];

  for (genvar g = 0; g < N; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        entry_q[g] <= RST_ENTRY;
      end else if (win_we_i && hit && (ent == IW'(g))) begin
        if (hi) entry_q[g][63:32] <= win_wdata_i;
        else    entry_q[g][31:0]  <= win_wdata_i & ~(32'd1 << RIRR_BIT);
      end
    end
    assign cfg_o[g].vector     = entry_q[g][VEC_W-1:0];
    assign cfg_o[g].dest       = entry_q[g][DEST_LSB +: DEST_W];
    assign cfg_o[g].active_low = entry_q[g][POL_BIT];
    assign cfg_o[g].level      = entry_q[g][TRIG_BIT];
    assign cfg_o[g].masked     = entry_q[g][MASK_BIT];
  end

  always_comb begin
    win_rdata_o = '0;
    if (hit) begin
      if (hi) begin
        win_rdata_o = entry_q[ent][63:32];
      end else begin
        win_rdata_o = entry_q[ent][31:0];
        win_rdata_o[RIRR_BIT] = rirr_i[ent];
      end
    end
  end
endmodule

// File: rtl/irq_rt_line.sv
module irq_rt_line (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic active_low_i,
  input  logic level_i,
  input  logic masked_i,
  input  logic grant_i,
  input  logic eoi_hit_i,
  output logic req_o,
  output logic rirr_o
);
  logic active, prev_q, pend_q, rirr_q, rise;

  assign active = line_i ^ active_low_i;
  assign rise   = active & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      rirr_q <= 1'b0;
    end else begin
      prev_q <= active;
      // edge captured only while unmasked; a grant retires it
      pend_q <= ~level_i & ((pend_q & ~grant_i) | (rise & ~masked_i));
      rirr_q <= level_i & ((rirr_q & ~eoi_hit_i) | grant_i);
    end
  end

  assign req_o  = ~masked_i & (level_i ? (active & ~rirr_q) : pend_q);
  assign rirr_o = rirr_q;
endmodule

// File: rtl/irq_rt_arbiter.sv
module irq_rt_arbiter #(
  parameter int N  = 24,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          adv_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] gnt_idx_o
);
  logic [IW-1:0] ptr_q;
  logic          found;

  always_comb begin
    found     = 1'b0;
    gnt_idx_o = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = int'(ptr_q) + k;
      if (j >= N) j = j - N;
      if (!found && req_i[j]) begin
        found     = 1'b1;
        gnt_idx_o = IW'(j);
      end
    end
    gnt_o = (found && adv_i) ? (N'(1) << gnt_idx_o) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (found && adv_i)
      ptr_q <= (32'(gnt_idx_o) == N - 1) ? '0 : gnt_idx_o + 1'b1;
  end
endmodule

// File: rtl/irq_redirect_router.sv
module irq_redirect_router
  import irq_rt_pkg::*;
#(
  parameter int NUM_LINES = 24,
  localparam int IW = $clog2(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_line_i,
  input  logic                 cfg_sel_we_i,
  input  logic [7:0]           cfg_sel_i,
  input  logic                 cfg_win_we_i,
  input  logic [31:0]          cfg_win_wdata_i,
  output logic [31:0]          cfg_win_rdata_o,
  input  logic                 eoi_valid_i,
  input  logic [VEC_W-1:0]     eoi_vector_i,
  output logic                 msg_valid_o,
  input  logic                 msg_ready_i,
  output logic [VEC_W-1:0]     msg_vector_o,
  output logic [DEST_W-1:0]    msg_dest_o
);
  line_cfg_t            cfg [NUM_LINES];
  logic [NUM_LINES-1:0] req_vec, grant_vec, rirr_vec, mask_vec;
  logic [IW-1:0]        gnt_idx;
  logic                 slot_free;

  assign slot_free = ~msg_valid_o | msg_ready_i;

  irq_rt_table #(.N(NUM_LINES)) u_table (
    .clk_i, .rst_ni,
    .sel_we_i(cfg_sel_we_i), .sel_i(cfg_sel_i),
    .win_we_i(cfg_win_we_i), .win_wdata_i(cfg_win_wdata_i),
    .win_rdata_o(cfg_win_rdata_o),
    .rirr_i(rirr_vec), .cfg_o(cfg)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign mask_vec[g] = cfg[g].masked;
    irq_rt_line u_line (
      .clk_i, .rst_ni,
      .line_i(irq_line_i[g]),
      .active_low_i(cfg[g].active_low),
      .level_i(cfg[g].level),
      .masked_i(cfg[g].masked),
      .grant_i(grant_vec[g]),
      .eoi_hit_i(eoi_valid_i && (cfg[g].vector == eoi_vector_i)),
      .req_o(req_vec[g]),
      .rirr_o(rirr_vec[g])
    );
  end

  irq_rt_arbiter #(.N(NUM_LINES)) u_arb (
    .clk_i, .rst_ni,
    .req_i(req_vec), .adv_i(slot_free),
    .gnt_o(grant_vec), .gnt_idx_o(gnt_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_valid_o  <= 1'b0;
      msg_vector_o <= '0;
      msg_dest_o   <= '0;
    end else if (slot_free) begin
      msg_valid_o <= |grant_vec;
      if (|grant_vec) begin
        msg_vector_o <= cfg[gnt_idx].vector;
        msg_dest_o   <= cfg[gnt_idx].dest;
      end
    end
  end
endmodule

// File: rtl/irq_rt_checker.sv
module irq_rt_checker #(
  parameter int N = 24
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         msg_valid_i,
  input logic         msg_ready_i,
  input logic [7:0]   msg_vector_i,
  input logic [7:0]   msg_dest_i,
  input logic [N-1:0] req_i,
  input logic [N-1:0] grant_i,
  input logic [N-1:0] rirr_i,
  input logic [N-1:0] mask_i
);
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_i && !msg_ready_i |=> msg_valid_i && $stable(msg_vector_i) && $stable(msg_dest_i));

  p_one_grant_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_i));

  p_grant_has_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i & ~req_i) == '0);

  p_masked_silent_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i & mask_i) == '0);

  p_rirr_from_grant_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rirr_i & ~$past(rirr_i) & ~$past(grant_i)) == '0);

  p_valid_from_grant_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msg_valid_i) |-> $past(|grant_i));
endmodule

bind irq_redirect_router irq_rt_checker #(.N(NUM_LINES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .msg_valid_i(msg_valid_o), .msg_ready_i(msg_ready_i),
  .msg_vector_i(msg_vector_o), .msg_dest_i(msg_dest_o),
  .req_i(req_vec), .grant_i(grant_vec),
  .rirr_i(rirr_vec), .mask_i(mask_vec)
);

// File: tb/irq_redirect_router_tb.sv
module irq_redirect_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 24;
  // line, expected vector, expected destination
  localparam logic [20:0] TBL [6] = '{
    {5'd0,  8'h30, 8'h01}, {5'd5,  8'h35, 8'h20}, {5'd11, 8'h3B, 8'h08},
    {5'd16, 8'h40, 8'h01}, {5'd23, 8'h47, 8'h80}, {5'd8,  8'h38, 8'h01}};

  logic clk = 0, rst_n = 0;
  logic [N-1:0] line = '0;
  logic sel_we = 0, win_we = 0, eoi_v = 0, rdy = 1;
  logic [7:0] sel = '0, eoi_vec = '0;
  logic [31:0] wdata = '0, rdata;
  logic valid;
  logic [7:0] vec, dst;
  int errors = 0, checks = 0, log_n = 0;
  logic [7:0] log_vec [64];
  logic [7:0] log_dst [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_redirect_router u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_line_i(line),
    .cfg_sel_we_i(sel_we), .cfg_sel_i(sel),
    .cfg_win_we_i(win_we), .cfg_win_wdata_i(wdata), .cfg_win_rdata_o(rdata),
    .eoi_valid_i(eoi_v), .eoi_vector_i(eoi_vec),
    .msg_valid_o(valid), .msg_ready_i(rdy), .msg_vector_o(vec), .msg_dest_o(dst));

  always @(posedge clk) if (rst_n && valid && rdy && log_n < 64) begin
    log_vec[log_n] = vec; log_dst[log_n] = dst; log_n = log_n + 1;
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] idx, logic [31:0] d);
    sel_we = 1; sel = idx; tick(1);
    sel_we = 0; win_we = 1; wdata = d; tick(1);
    win_we = 0;
  endtask

  task automatic rd(logic [7:0] idx, output logic [31:0] d);
    sel_we = 1; sel = idx; tick(1);
    sel_we = 0; d = rdata;
  endtask

  task automatic eoi(logic [7:0] v);
    eoi_v = 1; eoi_vec = v; tick(1); eoi_v = 0;
  endtask

  function automatic int nxt(int last);
    if (last < 3) return 3;
    if (last < 12) return 12;
    if (last < 20) return 20;
    return 3;
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int base, last, exp_line;
    tick(2);
    chk("R1 valid in reset", 32'(valid), 0);
    rst_n = 1; tick(1);
    rd(8'h10, d); chk("R1 entry0 low", d, 32'h0001_0000);
    rd(8'h3E, d); chk("R1 entry23 low", d, 32'h0001_0000);

    // R3: all masked after reset
    line = '1; tick(4); line = '0; tick(4);
    chk("R3 masked inputs", 32'(log_n), 0);

    // R2 window behaviour
    wr(8'h23, 32'hA500_0000); rd(8'h23, d); chk("R2 high half", d, 32'hA500_0000);
    wr(8'h22, 32'h0001_4039); rd(8'h22, d); chk("R2 bit14 readonly", d, 32'h0001_0039);
    wr(8'h40, 32'hFFFF_FFFF); rd(8'h40, d); chk("R2 out of range", d, 0);

    for (int n = 0; n < N; n++) begin
      wr(8'(8'h10 + 2*n), 32'(8'h30 + n));
      wr(8'(8'h11 + 2*n), 32'(1 << (n % 8)) << 24);
    end

    // R4 table walk
    for (int t = 0; t < 6; t++) begin
      base = log_n;
      line[TBL[t][20:16]] = 1'b1; tick(3);
      chk("R4 one message", 32'(log_n - base), 1);
      chk("R4 vector", 32'(log_vec[base]), 32'(TBL[t][15:8]));
      chk("R4 dest", 32'(log_dst[base]), 32'(TBL[t][7:0]));
      tick(3); chk("R4 held input quiet", 32'(log_n - base), 1);
      line[TBL[t][20:16]] = 1'b0; tick(2);
    end

    // R5 active low on line 2
    wr(8'h14, 32'h0001_0032); line[2] = 1; tick(2);
    wr(8'h14, 32'h0000_2052); tick(3);
    base = log_n;
    line[2] = 0; tick(3);
    chk("R5 falling edge count", 32'(log_n - base), 1);
    chk("R5 vector", 32'(log_vec[base]), 32'h52);
    line[2] = 1; tick(3); chk("R5 rising ignored", 32'(log_n - base), 1);

    // R6 level with remote pending on line 4
    wr(8'h18, 32'h0000_8064); base = log_n;
    line[4] = 1; tick(3);
    chk("R6 first message", 32'(log_n - base), 1);
    rd(8'h18, d); chk("R6 flag set", d, 32'h0000_C064);
    tick(5); chk("R6 blocked", 32'(log_n - base), 1);
    eoi(8'h65); tick(3); chk("R6 wrong eoi", 32'(log_n - base), 1);
    eoi(8'h64); tick(3); chk("R6 resend", 32'(log_n - base), 2);
    chk("R6 resend vector", 32'(log_vec[base+1]), 32'h64);
    // R7
    line[4] = 0; tick(1); eoi(8'h64); tick(3);
    chk("R7 no message", 32'(log_n - base), 2);
    rd(8'h18, d); chk("R7 flag clear", d, 32'h0000_8064);

    // R9 masked edge discarded on line 7
    wr(8'h1E, 32'h0001_0037); base = log_n;
    line[7] = 1; tick(3); wr(8'h1E, 32'h0000_0037); tick(4);
    chk("R9 masked edge", 32'(log_n - base), 0);
    line[7] = 0; tick(2);

    // R10 masked level on line 6
    wr(8'h1C, 32'h0001_8066); base = log_n;
    line[6] = 1; tick(4); chk("R10 masked level", 32'(log_n - base), 0);
    wr(8'h1C, 32'h0000_8066); tick(3);
    chk("R10 unmask sends", 32'(log_n - base), 1);
    chk("R10 vector", 32'(log_vec[base]), 32'h66);
    line[6] = 0; tick(1); eoi(8'h66); tick(2);
    last = 6;

    // R8 / R11 contention
    for (int round = 0; round < 2; round++) begin
      base = log_n; rdy = 0;
      line[3] = 1; line[12] = 1; line[20] = 1; tick(4);
      d = 32'(vec); tick(2);
      chk("R11 held valid", 32'(valid), 1);
      chk("R11 held vector", 32'(vec), d);
      rdy = 1; tick(6);
      chk("R8 all delivered", 32'(log_n - base), 3);
      exp_line = last;
      for (int k = 0; k < 3; k++) begin
        exp_line = nxt(exp_line);
        chk("R8 order", 32'(log_vec[base+k]), 32'(8'h30 + exp_line));
      end
      last = exp_line;
      line[3] = 0; line[12] = 0; line[20] = 0; tick(2);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule